// File: doc/BRIEF.md
# Staged Serial-Bit Control Register File

This block holds sixteen one-bit control ports behind a narrow window of a CPU-style bus. Each access reaches a single port. The port number comes from the bank field of the address, and the bit travels on the top line of the data bus. A write does not change the controls that feed the memory-mapping logic straight away. The bit is first placed in a staging array. A write to a dedicated commit port then copies the staged mapping bits, ports 2 to 13, into an applied array in one step. The applied array drives the `ctl_applied` output.

Port 15 is a mode bit. While it is set, every read returns a bit from an eight-entry shadow array, selected by the low three index bits. Every write made while it was already set also records its data bit in that shadow array. The shadow array comes up as 0x3F at power-on and keeps its contents through the reset line. Port 0 reads the ready-interrupt flag. An external ready event sets this flag, and any write to port 0 acknowledges it. Port 1 holds the interrupt enable and takes effect as soon as it is written.

Top module: `ctrl_bit_bank`

## Requirements
- R1: After reset the staging and applied arrays both hold 0x0BEC, the interrupt flag is 0 and `irq` is low. The shadow array is outside this rule (see R8).
- R2: A bus address hits the window when bits 23:20 are 0 and bits 15:12 are 0x5. The port index is address bits 19:16, and every offset 0x5000–0x5FFF is the same port. Data bit 7 carries the port bit. On a read hit `bus_rdata_oe` is 0x80 and `bus_rdata[6:0]` is 0. Accesses outside the window change no state, and reads outside it drive nothing (`bus_rdata_oe` = 0).
- R3: A write stores its data bit into the staging array at the written index. Reads of ports 2–13 and `ctl_applied` do not change until a commit.
- R4: A write of any value to index 14 copies staged bits 2–13 into the applied array.
- R5: With staged bit 15 clear, reads return the following: index 0 gives the interrupt flag, index 1 gives staged bit 1, indices 2–13 give the applied bits, and indices 14–15 give 0.
- R6: With staged bit 15 set, a read of index i returns shadow bit (i AND 7).
- R7: A write stores its data bit into shadow bit (index AND 7) only if staged bit 15 was already 1 before that write. The write that sets bit 15 leaves the shadow array untouched. A write of 0 to index 15 while the mode is set stores 0 into shadow bit 7.
- R8: The shadow array holds 0x3F at power-on and is not changed by the reset line.
- R9: A one-cycle ready event sets the interrupt flag. A write of any value to index 0 clears it.
- R10: When a ready event and a write to index 0 fall in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when the interrupt flag is 1 and staged bit 1 is 1, and it stays high until acknowledged or disabled.
- R12: `ctl_applied` shows applied bits 2–13 in their own positions, with bits 0, 1, 14 and 15 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | Bus address (bank in 23:16, offset in 15:0) |
| bus_wdata | input | 8 | Write data, bit 7 used |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| ready_evt | input | 1 | External ready-event pulse |
| bus_rdata | output | 8 | Read data, port bit on bit 7 |
| bus_rdata_oe | output | 8 | Per-bit drive enable of bus_rdata |
| irq | output | 1 | Ready interrupt, active-high level |
| ctl_applied | output | 16 | Applied control vector |

## Verification
The acknowledge write to port 0 and the external ready event both act on the interrupt flag, so the two can collide in one cycle. The bench provokes this by raising `ready_evt` in the same cycle as the write strobe to index 0, with the enable set. The flag read back on port 0 must then be 1 and `irq` must stay high. A separate acknowledge-only write follows and must bring both low, which shows that the set won the collision rather than the clear never happening.

// File: rtl/cbank_pkg.sv
package cbank_pkg;
    localparam int NPORT = 16;

    typedef struct packed {
        logic [NPORT-1:0] stg;
        logic [NPORT-1:0] app;
        logic             flag;
    } cb_state_t;
endpackage

// File: rtl/cb_decode.sv
module cb_decode #(
    parameter int ADDR_W = 24,
    parameter int IDX_W = 4,
    parameter int OFS_W = 16,
    parameter int PAGE_W = 4,
    parameter logic [3:0] WIN_PAGE = 4'h5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int BANK_TOP = ADDR_W - OFS_W - IDX_W;

    logic bank_ok;
    logic page_ok;
    logic [OFS_W-PAGE_W-1:0] unused_ofs;

    generate
        if (BANK_TOP > 0) begin : g_bank_hi
            assign bank_ok = (addr[ADDR_W-1:OFS_W+IDX_W] == '0);
        end else begin : g_bank_all
            assign bank_ok = 1'b1;
        end
    endgenerate

    assign page_ok    = (addr[OFS_W-1:OFS_W-PAGE_W] == WIN_PAGE);
    assign unused_ofs = addr[OFS_W-PAGE_W-1:0];
    assign hit        = bank_ok && page_ok;
    assign idx        = addr[OFS_W+IDX_W-1:OFS_W];
endmodule

// File: rtl/cb_core.sv
module cb_core
    import cbank_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int HID_W = 8,
    parameter int APPLY_LO = 2,
    parameter int APPLY_HI = 13,
    parameter int COMMIT_IDX = 14,
    parameter int MODE_IDX = 15,
    parameter int ACK_IDX = 0,
    parameter logic [NPORT-1:0] RST_VAL = 16'h0BEC,
    parameter logic [HID_W-1:0] HID_INIT = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit,
    input  logic              ready_evt,
    output logic [NPORT-1:0]  stg_q,
    output logic [NPORT-1:0]  app_q,
    output logic [HID_W-1:0]  hid_q,
    output logic              flag_q
);
    localparam int HID_AW = $clog2(HID_W);
    localparam logic [IDX_W-1:0] COMMIT_I = IDX_W'(COMMIT_IDX);
    localparam logic [IDX_W-1:0] ACK_I    = IDX_W'(ACK_IDX);

    cb_state_t st_d, st_q;
    logic [HID_W-1:0] hid_d;
    logic [HID_W-1:0] hid_r = HID_INIT;

    always_comb begin
        st_d  = st_q;
        hid_d = hid_r;
        if (wr_hit) begin
            if (st_q.stg[MODE_IDX]) begin
                hid_d[wr_idx[HID_AW-1:0]] = wr_bit;
            end
            st_d.stg[wr_idx] = wr_bit;
            if (wr_idx == COMMIT_I) begin
                for (int b = APPLY_LO; b <= APPLY_HI; b++) begin
                    st_d.app[b] = st_q.stg[b];
                end
            end
            if (wr_idx == ACK_I) begin
                st_d.flag = 1'b0;
            end
        end
        if (ready_evt) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stg  <= RST_VAL;
            st_q.app  <= RST_VAL;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // shadow array deliberately has no reset term
    always_ff @(posedge clk) begin
        if (rst_n) begin
            hid_r <= hid_d;
        end
    end

    assign stg_q  = st_q.stg;
    assign app_q  = st_q.app;
    assign hid_q  = hid_r;
    assign flag_q = st_q.flag;

    // R4: a commit write copies the staged mapping bits
    assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_idx == COMMIT_I) |=>
            (app_q[APPLY_HI:APPLY_LO] == $past(stg_q[APPLY_HI:APPLY_LO])));

    // R3: applied array only moves on a commit
    assert_applied_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && wr_idx == COMMIT_I) |=> $stable(app_q));

    // R9 / R10: a ready event always leaves the flag set
    assert_event_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_evt |=> flag_q);

    // R9: flag falls only after an acknowledge write
    assert_flag_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(wr_hit && wr_idx == ACK_I));

    // R7: shadow array is untouched while the mode bit is clear
    assert_hid_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stg_q[MODE_IDX] |=> $stable(hid_q));
endmodule

// File: rtl/cb_readmux.sv
module cb_readmux
    import cbank_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int HID_W = 8,
    parameter int APPLY_LO = 2,
    parameter int APPLY_HI = 13,
    parameter int MODE_IDX = 15,
    parameter int FLAG_IDX = 0,
    parameter int EN_IDX = 1
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [NPORT-1:0]  stg,
    input  logic [NPORT-1:0]  app,
    input  logic [HID_W-1:0]  hid,
    input  logic              flag,
    output logic              rbit
);
    localparam int HID_AW = $clog2(HID_W);

    always_comb begin
        if (stg[MODE_IDX]) begin
            rbit = hid[idx[HID_AW-1:0]];
        end else if (int'(idx) == FLAG_IDX) begin
            rbit = flag;
        end else if (int'(idx) == EN_IDX) begin
            rbit = stg[EN_IDX];
        end else if (int'(idx) >= APPLY_LO && int'(idx) <= APPLY_HI) begin
            rbit = app[idx];
        end else begin
            rbit = 1'b0;
        end
    end
endmodule

// File: rtl/ctrl_bit_bank.sv
module ctrl_bit_bank
    import cbank_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int IDX_W = 4,
    parameter int HID_W = 8,
    parameter int APPLY_LO = 2,
    parameter int APPLY_HI = 13,
    parameter int EN_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              ready_evt,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] bus_rdata_oe,
    output logic              irq,
    output logic [NPORT-1:0]  ctl_applied
);
    localparam int BIT_POS = DATA_W - 1;

    function automatic logic [NPORT-1:0] apply_mask();
        logic [NPORT-1:0] m = '0;
        for (int b = APPLY_LO; b <= APPLY_HI; b++) m[b] = 1'b1;
        return m;
    endfunction
    localparam logic [NPORT-1:0] APPLY_MASK = apply_mask();

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [NPORT-1:0] stg_q, app_q;
    logic [HID_W-1:0] hid_q;
    logic             flag_q;
    logic             rbit;
    logic [BIT_POS-1:0] unused_wlow;

    assign unused_wlow = bus_wdata[BIT_POS-1:0];

    cb_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    cb_core #(.IDX_W(IDX_W), .HID_W(HID_W), .APPLY_LO(APPLY_LO), .APPLY_HI(APPLY_HI)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (bus_wr && hit),
        .wr_idx    (idx),
        .wr_bit    (bus_wdata[BIT_POS]),
        .ready_evt (ready_evt),
        .stg_q     (stg_q),
        .app_q     (app_q),
        .hid_q     (hid_q),
        .flag_q    (flag_q)
    );

    cb_readmux #(.IDX_W(IDX_W), .HID_W(HID_W), .APPLY_LO(APPLY_LO), .APPLY_HI(APPLY_HI),
                 .EN_IDX(EN_IDX)) u_rmux (
        .idx  (idx),
        .stg  (stg_q),
        .app  (app_q),
        .hid  (hid_q),
        .flag (flag_q),
        .rbit (rbit)
    );

    assign bus_rdata    = {rbit, {BIT_POS{1'b0}}};
    assign bus_rdata_oe = (bus_rd && hit) ? {1'b1, {BIT_POS{1'b0}}} : '0;
    assign irq          = flag_q && stg_q[EN_IDX];
    assign ctl_applied  = app_q & APPLY_MASK;

    // R11: interrupt output only with the enable set
    assert_irq_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stg_q[EN_IDX]);
endmodule

// File: tb/sim_ctrl_bit_bank.sv
module sim_ctrl_bit_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        ready_evt = 1'b0;
    logic [7:0]  bus_rdata, bus_rdata_oe;
    logic        irq;
    logic [15:0] ctl_applied;

    int n_run = 0;
    int n_fail = 0;
    logic rb;

    always #4 clk = ~clk;

    ctrl_bit_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .ready_evt(ready_evt),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .irq(irq),
        .ctl_applied(ctl_applied)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] pa(input int idx, input logic [11:0] ofs);
        return {4'h0, 4'(idx), 4'h5, ofs};
    endfunction

    task automatic wr_raw(input logic [23:0] a, input logic b, input logic ev);
        @(negedge clk);
        bus_addr = a; bus_wdata = {b, 7'h55}; bus_wr = 1'b1; ready_evt = ev;
        @(negedge clk);
        bus_wr = 1'b0; ready_evt = 1'b0;
    endtask

    task automatic wr(input int idx, input logic b);
        wr_raw(pa(idx, 12'h000), b, 1'b0);
    endtask

    task automatic rd_raw(input logic [23:0] a, output logic b);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        b = bus_rdata[7];
        chk("R2 low data bits", {25'd0, bus_rdata[6:0]}, 32'd0);
        chk("R2 drive mask", {24'd0, bus_rdata_oe}, 32'h80);
        bus_rd = 1'b0;
    endtask

    task automatic rd(input int idx, output logic b);
        rd_raw(pa(idx, 12'h000), b);
    endtask

    task automatic pulse_ready();
        @(negedge clk);
        ready_evt = 1'b1;
        @(negedge clk);
        ready_evt = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] rv = 16'h0BEC;
        for (int i = 2; i <= 13; i++) begin
            rd(i, rb); chk("R1 R5 applied after reset", rb, rv[i]);
        end
        rd(0, rb);  chk("R1 R5 flag idx0", rb, 1'b0);
        rd(1, rb);  chk("R1 R5 enable idx1", rb, 1'b0);
        rd(14, rb); chk("R5 idx14 zero", rb, 1'b0);
        rd(15, rb); chk("R5 idx15 zero", rb, 1'b0);
        chk("R1 R12 ctl_applied", ctl_applied, 16'h0BEC);
        chk("R1 irq low", irq, 1'b0);
    endtask

    task automatic t_hidden_powerup();
        wr(15, 1'b1);
        for (int i = 0; i < 16; i++) begin
            rd(i, rb); chk("R6 R8 shadow power-up", rb, (i % 8) < 6);
        end
        wr(15, 1'b0);
        rd(2, rb); chk("R5 mode off again", rb, 1'b1);
    endtask

    task automatic t_staging();
        wr(4, 1'b1);
        rd(4, rb); chk("R3 staged not visible", rb, 1'b0);
        chk("R3 ctl_applied held", ctl_applied, 16'h0BEC);
        wr(14, 1'b0);
        rd(4, rb); chk("R4 commit visible", rb, 1'b1);
        chk("R4 R12 ctl_applied", ctl_applied, 16'h0BFC);
        wr_raw({8'h03, 16'h5ABC}, 1'b0, 1'b0);
        wr_raw({8'h0E, 16'h5FFF}, 1'b1, 1'b0);
        rd_raw({8'h03, 16'h5777}, rb); chk("R2 mirror offsets", rb, 1'b0);
        chk("R2 R4 ctl_applied", ctl_applied, 16'h0BF4);
    endtask

    task automatic t_outside();
        wr_raw({8'h14, 16'h5000}, 1'b0, 1'b0);
        wr_raw({8'h04, 16'h6000}, 1'b0, 1'b0);
        wr(14, 1'b0);
        rd(4, rb); chk("R2 outside writes ignored", rb, 1'b1);
        @(negedge clk);
        bus_addr = {8'h04, 16'h4FFF}; bus_rd = 1'b1;
        #1 chk("R2 no drive outside", {24'd0, bus_rdata_oe}, 32'd0);
        bus_rd = 1'b0;
    endtask

    task automatic t_hidden_write();
        wr(15, 1'b1);
        rd(7, rb); chk("R7 setting write leaves shadow", rb, 1'b0);
        wr(10, 1'b0);
        rd(2, rb);  chk("R7 shadow bit2 written", rb, 1'b0);
        rd(10, rb); chk("R6 mirror index 10", rb, 1'b0);
        rd(0, rb);  chk("R6 shadow bit0", rb, 1'b1);
        wr(15, 1'b1);
        rd(7, rb);  chk("R7 shadow bit7 set", rb, 1'b1);
        wr(15, 1'b0);
        rd(2, rb);  chk("R5 applied back after mode off", rb, 1'b1);
        wr(15, 1'b1);
        rd(7, rb);  chk("R7 clearing write stored bit7", rb, 1'b0);
        wr(15, 1'b0);
    endtask

    task automatic t_reset_keeps();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        rd(4, rb); chk("R1 staged/applied reset", rb, 1'b0);
        chk("R1 ctl_applied reset", ctl_applied, 16'h0BEC);
        wr(15, 1'b1);
        rd(2, rb); chk("R8 shadow survives reset", rb, 1'b0);
        rd(3, rb); chk("R8 shadow bit3", rb, 1'b1);
        wr(15, 1'b0);
    endtask

    task automatic t_irq();
        pulse_ready();
        rd(0, rb); chk("R9 flag set", rb, 1'b1);
        chk("R11 irq off without enable", irq, 1'b0);
        wr(1, 1'b1);
        chk("R11 irq with enable", irq, 1'b1);
        rd(1, rb); chk("R5 idx1 reads enable", rb, 1'b1);
        repeat (3) @(negedge clk);
        chk("R11 irq level held", irq, 1'b1);
        wr(0, 1'b1);
        rd(0, rb); chk("R9 ack clears", rb, 1'b0);
        chk("R11 irq after ack", irq, 1'b0);
    endtask

    task automatic t_collision();
        wr_raw(pa(0, 12'h000), 1'b0, 1'b1);
        rd(0, rb); chk("R10 set wins", rb, 1'b1);
        chk("R10 irq stays", irq, 1'b1);
        wr(1, 1'b0);
        chk("R11 irq disabled", irq, 1'b0);
        rd(0, rb); chk("R11 flag kept", rb, 1'b1);
        wr(0, 1'b0);
        rd(0, rb); chk("R10 later ack clears", rb, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hidden_powerup();
        t_staging();
        t_outside();
        t_hidden_write();
        t_reset_keeps();
        t_irq();
        t_collision();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule